// File: doc/BRIEF.md
# Local Bus Interrupt Aggregator

This block gathers sixteen level-sensitive interrupt lines from local bus devices into one interrupt request for the processor. Each line's level is captured by a clock register. That register is the pending source state. The pending state is ANDed with an enable mask that software owns, and the block raises its single request output whenever any enabled line is pending.

Software reaches the block through a small 16-bit register port with two registers. The first, at offset 0x00, is read-only. It does not return a bitmap. It returns a vector code that names the lowest-numbered line that is both pending and enabled. The code is that line's index plus one, shifted left by two bits, so an interrupt handler can use it directly as a byte offset into a table of handlers. The code is zero when nothing is pending. The second register, at offset 0x02, holds the enable mask and can be read and written. Lines are cleared only by the devices themselves, by dropping their levels. A read never clears anything.

Top module: `lbirq_top`

## Requirements
- R1: Each interrupt line is sampled by a clock register, so a change of level becomes visible at the outputs after the next rising clock edge and not before it.
- R2: `irqOut` is 1 exactly when the bitwise AND of the sampled lines and the enable mask is nonzero.
- R3: A read of offset 0x00 returns (n+1)<<2, where n is the lowest-numbered bit set in (sampled lines AND mask). For example, line 0 gives 0x0004, line 4 gives 0x0014 and line 15 gives 0x0040.
- R4: A read of offset 0x00 returns 0 when no enabled line is pending.
- R5: A write to offset 0x02 loads the enable mask from `regWrData`, and a read of offset 0x02 returns the mask. Bit k of the mask enables line k.
- R6: After reset, the mask reads 0x0010, so only line 4 is enabled. The sampled source state is 0, and `irqOut` is 0.
- R7: Reads of any offset other than 0x00 or 0x02 return 0. Writes to any offset other than 0x02, including 0x00, change nothing.
- R8: Reading offset 0x00 leaves the pending state unchanged, so repeated reads return the same code.
- R9: A mask write takes effect at the clock edge that accepts it. `irqOut` and the vector code follow the new mask from that edge on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| irqLines | input | 16 | Level-sensitive interrupt lines; bit k is line k |
| regAddr | input | 12 | Byte offset of the register access |
| regWrEn | input | 1 | Write strobe, accepted on the rising edge |
| regRdEn | input | 1 | Read strobe; read data is combinational |
| regWrData | input | 16 | Write data |
| regRdData | output | 16 | Read data; 0 when no read is strobed |
| irqOut | output | 1 | Combined interrupt request |

## Verification
A corrupted enable mask shows up at the first access: the mask readback at 0x02 is wrong, and the vector code at 0x00 points at a line that should be masked, or at none at all. Both show in the same cycle as the read. A fault in the source register or the sampling stage shows up one clock after a line changes. At that point `irqOut` and the vector code disagree with the driven levels. The directed tests change one line or one mask bit at a time, so that every such error shows up at a known cycle.

// File: rtl/lbirq_pkg.sv
package lbirq_pkg;
  // Register strobes from the decode logic to the datapath.
  typedef struct packed {
    logic wrMask;
    logic rdVec;
    logic rdMask;
  } regStrobe_t;
endpackage

// File: rtl/lbirq_ctrl.sv
module lbirq_ctrl
  import lbirq_pkg::*;
#(
  parameter int ADDR_W   = 12,
  parameter int VEC_OFS  = 'h0,
  parameter int MASK_OFS = 'h2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              regWrEn,
  input  logic              regRdEn,
  output regStrobe_t        strobe
);
  localparam logic [ADDR_W-1:0] VecAddr  = ADDR_W'(VEC_OFS);
  localparam logic [ADDR_W-1:0] MaskAddr = ADDR_W'(MASK_OFS);

  logic hitVec;
  logic hitMask;

  always_comb begin
    hitVec        = (regAddr == VecAddr);
    hitMask       = (regAddr == MaskAddr);
    strobe.rdVec  = regRdEn & hitVec;
    strobe.rdMask = regRdEn & hitMask;
    // The vector register is read-only, so only the mask has a write strobe.
    strobe.wrMask = regWrEn & hitMask;
  end

  // R7: at most one register is selected for reading at a time.
  a_r7_one_read_target: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobe.rdVec, strobe.rdMask}));

  // R7: a write to any offset other than the mask produces no write strobe.
  a_r7_no_stray_write: assert property (@(posedge clk) disable iff (!rstN)
    (regWrEn && regAddr != MaskAddr) |-> !strobe.wrMask);
endmodule

// File: rtl/lbirq_dpath.sv
module lbirq_dpath
  import lbirq_pkg::*;
#(
  parameter int N_LINES  = 16,
  parameter int DATA_W   = 16,
  parameter int MASK_RST = 'h0010
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [N_LINES-1:0] irqLines,
  input  regStrobe_t         strobe,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  output logic               irqOut
);
  localparam int IDX_W = $clog2(N_LINES);

  logic [N_LINES-1:0] srcReg;
  logic [N_LINES-1:0] maskReg;
  logic [N_LINES-1:0] pending;
  logic [IDX_W-1:0]   lowIdx;
  logic               anyPend;
  logic [IDX_W:0]     idxPlus;
  logic [DATA_W-1:0]  vecCode;

  // R1/R6: one sampling stage; this register is the source state.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) srcReg <= '0;
    else       srcReg <= irqLines;
  end

  // R5/R6/R9: enable mask.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              maskReg <= N_LINES'(MASK_RST);
    else if (strobe.wrMask) maskReg <= regWrData[N_LINES-1:0];
  end

  assign pending = srcReg & maskReg;

  // R3: search from high to low, so the lowest pending line wins.
  always_comb begin
    anyPend = 1'b0;
    lowIdx  = '0;
    for (int i = N_LINES - 1; i >= 0; i--) begin
      if (pending[i]) begin
        anyPend = 1'b1;
        lowIdx  = IDX_W'(i);
      end
    end
    idxPlus = {1'b0, lowIdx} + 1'b1;
    vecCode = anyPend ? DATA_W'({idxPlus, 2'b00}) : '0;   // R4
  end

  assign irqOut = |pending;

  always_comb begin
    regRdData = '0;
    if (strobe.rdVec)  regRdData = vecCode;
    if (strobe.rdMask) regRdData = DATA_W'(maskReg);
  end

  // R2: the OR reduction and the priority encoder agree on whether a line is pending.
  a_r2_irq_vs_code: assert property (@(posedge clk) disable iff (!rstN)
    irqOut == (vecCode != '0));

  // R3: the encoded line is pending, and no lower line is pending.
  a_r3_lowest_line: assert property (@(posedge clk) disable iff (!rstN)
    anyPend |-> (pending[lowIdx] &&
                 ((pending & ((N_LINES'(1) << lowIdx) - N_LINES'(1))) == '0)));

  // R5: a mask write is visible after the edge that accepts it.
  a_r5_mask_load: assert property (@(posedge clk) disable iff (!rstN)
    strobe.wrMask |=> (maskReg == $past(regWrData[N_LINES-1:0])));

  // R7: the mask holds when it is not written.
  a_r7_mask_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.wrMask |=> $stable(maskReg));
endmodule

// File: rtl/lbirq_top.sv
module lbirq_top
  import lbirq_pkg::*;
#(
  parameter int N_LINES  = 16,
  parameter int DATA_W   = 16,
  parameter int ADDR_W   = 12,
  parameter int MASK_RST = 'h0010
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [N_LINES-1:0] irqLines,
  input  logic [ADDR_W-1:0]  regAddr,
  input  logic               regWrEn,
  input  logic               regRdEn,
  input  logic [DATA_W-1:0]  regWrData,
  output logic [DATA_W-1:0]  regRdData,
  output logic               irqOut
);
  regStrobe_t strobe;

  lbirq_ctrl #(
    .ADDR_W  (ADDR_W),
    .VEC_OFS ('h0),
    .MASK_OFS('h2)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .regAddr(regAddr),
    .regWrEn(regWrEn),
    .regRdEn(regRdEn),
    .strobe (strobe)
  );

  lbirq_dpath #(
    .N_LINES (N_LINES),
    .DATA_W  (DATA_W),
    .MASK_RST(MASK_RST)
  ) u_dpath (
    .clk      (clk),
    .rstN     (rstN),
    .irqLines (irqLines),
    .strobe   (strobe),
    .regWrData(regWrData),
    .regRdData(regRdData),
    .irqOut   (irqOut)
  );
endmodule

// File: tb/lbirq_top_tb.sv
`timescale 1ns/1ps
module lbirq_top_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] irqLines = '0;
  logic [11:0] regAddr = '0;
  logic        regWrEn = 1'b0;
  logic        regRdEn = 1'b0;
  logic [15:0] regWrData = '0;
  logic [15:0] regRdData;
  logic        irqOut;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;   // 125 MHz

  lbirq_top u_dut (
    .clk(clk), .rstN(rstN), .irqLines(irqLines), .regAddr(regAddr),
    .regWrEn(regWrEn), .regRdEn(regRdEn), .regWrData(regWrData),
    .regRdData(regRdData), .irqOut(irqOut)
  );

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, actual, expected);
    end
  endtask

  task automatic readReg(input logic [11:0] addr, output logic [15:0] data);
    @(negedge clk);
    regAddr = addr; regRdEn = 1'b1;
    #1 data = regRdData;
    @(negedge clk);
    regRdEn = 1'b0;
  endtask

  task automatic writeReg(input logic [11:0] addr, input logic [15:0] data);
    @(negedge clk);
    regAddr = addr; regWrData = data; regWrEn = 1'b1;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic setLines(input logic [15:0] v);
    @(negedge clk);
    irqLines = v;
    @(negedge clk);   // one rising edge has sampled the lines
  endtask

  task automatic testReset();
    logic [15:0] d;
    check("R6 irqOut", int'(irqOut), 0);
    readReg(12'h002, d); check("R6 mask", int'(d), 'h0010);
    readReg(12'h000, d); check("R6 vector", int'(d), 0);
  endtask

  task automatic testSyncAndLine4();
    logic [15:0] d;
    @(negedge clk);
    irqLines = 16'h0010;
    #1 check("R1 no change before edge", int'(irqOut), 0);
    @(negedge clk);
    check("R1 R2 irq after edge", int'(irqOut), 1);
    readReg(12'h000, d); check("R3 line4 code", int'(d), 'h14);
  endtask

  task automatic testMaskedLine();
    logic [15:0] d;
    setLines(16'h0018);             // lines 3 and 4; line 3 masked
    readReg(12'h000, d); check("R3 masked line ignored", int'(d), 'h14);
    setLines(16'h0008);             // only masked line 3
    check("R2 masked only", int'(irqOut), 0);
    readReg(12'h000, d); check("R4 nothing enabled", int'(d), 0);
  endtask

  task automatic testMaskWrite();
    logic [15:0] d;
    @(negedge clk);
    regAddr = 12'h002; regWrData = 16'hFFFF; regWrEn = 1'b1;
    #1 check("R9 before edge", int'(irqOut), 0);
    @(negedge clk);
    regWrEn = 1'b0;
    check("R9 after edge", int'(irqOut), 1);
    readReg(12'h002, d); check("R5 mask readback", int'(d), 'hFFFF);
    readReg(12'h000, d); check("R3 line3 code", int'(d), 'h10);
  endtask

  task automatic testPriority();
    logic [15:0] d;
    setLines(16'h8001);
    readReg(12'h000, d); check("R3 line0 wins", int'(d), 'h04);
    setLines(16'h8000);
    readReg(12'h000, d); check("R3 line15 code", int'(d), 'h40);
    readReg(12'h000, d); check("R8 repeat read", int'(d), 'h40);
    check("R8 irq still high", int'(irqOut), 1);
  endtask

  task automatic testIgnored();
    logic [15:0] d;
    writeReg(12'h000, 16'h0000);
    writeReg(12'h006, 16'h0000);
    readReg(12'h002, d); check("R7 mask untouched", int'(d), 'hFFFF);
    readReg(12'h000, d); check("R7 vector untouched", int'(d), 'h40);
    readReg(12'h004, d); check("R7 unlisted read", int'(d), 0);
    readReg(12'h001, d); check("R7 odd offset read", int'(d), 0);
  endtask

  task automatic testMaskOff();
    logic [15:0] d;
    writeReg(12'h002, 16'h0000);
    check("R2 mask cleared", int'(irqOut), 0);
    readReg(12'h000, d); check("R4 mask cleared", int'(d), 0);
    writeReg(12'h002, 16'h4000);
    setLines(16'hC000);
    readReg(12'h000, d); check("R5 R3 line14", int'(d), 'h3C);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rstN = 1'b1;
        @(negedge clk);
        testReset();
        testSyncAndLine4();
        testMaskedLine();
        testMaskWrite();
        testPriority();
        testIgnored();
        testMaskOff();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; failures++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule